// File: doc/BRIEF.md
# Cipher Accelerator Control and Key Register Block

This block is the register front end of a block-cipher accelerator. A 32-bit register bus writes and reads one control word, one status word and a bank of key words, eight 32-bit words for each of four channels. The control word sets the cipher mode, the direction, the key length, the data byte-order swaps, the DMA and cascade options and the working channel. It also carries three command bits, start, stop and last-block. These act on the bus write that carries them and are never stored where a read would see them. The block drives all the settings to the cipher engine as plain levels, together with the full key of the selected channel. Key words beyond the selected key length are driven as zero.

A two-state machine tracks whether the engine is working. In `ST_IDLE`, an accepted start takes it to `ST_BUSY` (transition `T_LAUNCH`). In `ST_BUSY`, a done pulse from the engine (`T_FINISH`) or a stop command (`T_ABORT`) takes it back to `ST_IDLE`. While the block is busy, the key-length field and the unlock field ignore writes. Key reads can be blocked by a protect flag. The only way to clear that flag is an unlock write, and an unlock write also erases every key word of every channel.

Top module: `cipher_ctl_regs`

## Requirements
- R1: After reset every stored field, every key word, the protect flag and `busy_o` are 0, and both the control word (address 0) and the status word (address 1) read 0.
- R2: In `ST_IDLE`, a control write with bit 0 set and bit 1 clear raises `busy_o` from the next cycle and pulses `start_o` for exactly one cycle. Bits 0, 1 and 5 of the control word always read 0.
- R3: `busy_o` returns to 0 one cycle after an `eng_done` pulse or after a control write with bit 1 set, and `stop_o` pulses for one cycle on that write. When bits 0 and 1 are written together in `ST_IDLE`, stop wins: `busy_o` stays 0 and `start_o` does not pulse. A start written while busy produces no pulse.
- R4: While `busy_o` is 1, writes leave the key-length field (bits 3:2) and the unlock field (bits 30:26) unchanged. The other control fields still take the written value.
- R5: The control fields can be read back and drive the outputs as follows: opmode in bits 15:8 (ECB 0x00, CBC 0x01, CFB 0x02, OFB 0x03, CTR 0x04, stealing variants 0x10, 0x11, 0x12), encrypt in bit 16 (1 = encrypt), DMA enable in bit 7, cascade in bit 6, output swap in bit 22, input swap in bit 23, channel in bits 25:24. Bits 4 and 21:17 read 0.
- R6: Writing bit 5 sets `last_o`. An accepted start clears `last_o` unless that same write also sets bit 5.
- R7: A control write with bit 31 set raises the protect flag, which reads back in bit 31. While the flag is set, every key-word read returns 0, and `key_o` still carries the key.
- R8: A control write with bit 31 clear and bits 30:26 = 10110, made while not busy, clears the protect flag and zeroes all key words of all channels. Any other pattern in bits 30:26 with bit 31 clear leaves the flag and the keys unchanged.
- R9: Key word w of channel c sits at word address 32 + 8c + w. `key_o` holds the selected channel's words with word 0 in bits 31:0. The key-length code in bits 3:2 keeps words 0–3 (code 0, 128 bits), 0–5 (code 1, 192 bits) or 0–7 (codes 2 and 3, 256 bits), and drives the remaining words as 0.
- R10: The status word holds `busy_o` in bit 0. Writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| busy_o | output | 1 | Engine working flag |
| start_o | output | 1 | One-cycle start command |
| stop_o | output | 1 | One-cycle stop command |
| last_o | output | 1 | Last-block flag |
| keysz_o | output | 2 | Key-length code |
| opmode_o | output | 8 | Cipher mode code |
| encrypt_o | output | 1 | 1 = encrypt, 0 = decrypt |
| dma_en_o | output | 1 | DMA data movement enable |
| cascade_o | output | 1 | DMA cascade enable |
| swap_in_o | output | 1 | Reverse byte order of input words |
| swap_out_o | output | 1 | Reverse byte order of output words |
| chan_o | output | 2 | Working channel |
| key_o | output | 256 | Key of the working channel, length-masked |

## Verification
The bench loads a distinct value into every key word of every channel and reads all of them back. It then checks `key_o` for every channel against every length code, so a word that is mis-addressed or masked at the wrong boundary shows up as a wrong word. It applies all 31 wrong unlock patterns while the key is protected. A design that decodes the pattern loosely would drop the flag or wipe the key, and `key_o` would show it. It also tries the correct pattern during `ST_BUSY`, where a missing busy lock would erase the key in mid-operation. Further cases cover a write to the length field while busy, start and stop written together, start written while already busy, and the clearing of the last-block flag on start. In each of these, a wrong priority shows up as a changed readback, a wrong `busy_o` or a stray pulse on `start_o`.

// File: rtl/cc_pkg.sv
package cc_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } cc_state_e;

    // control word bit positions
    localparam int B_START   = 0;
    localparam int B_STOP    = 1;
    localparam int B_LAST    = 5;
    localparam int B_CASCADE = 6;
    localparam int B_DMA     = 7;
    localparam int B_ENC     = 16;
    localparam int B_SWOUT   = 22;
    localparam int B_SWIN    = 23;
    localparam int B_PROT    = 31;

    localparam logic [4:0] UNLOCK_CODE = 5'b10110;

    localparam int WORD_W = 32;

endpackage

// File: rtl/cc_busy_fsm.sv
module cc_busy_fsm
    import cc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_start,
    input  logic cmd_stop,
    input  logic eng_done,
    output logic busy_o,
    output logic start_o,
    output logic stop_o
);

    cc_state_e state_q;
    cc_state_e state_d;
    logic      launch;

    // next-state logic
    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_start && !cmd_stop) begin
                    state_d = ST_BUSY;   // T_LAUNCH
                    launch  = 1'b1;
                end
            end
            ST_BUSY: begin
                if (cmd_stop || eng_done) begin
                    state_d = ST_IDLE;   // T_ABORT / T_FINISH
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered command pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_o <= 1'b0;
            stop_o  <= 1'b0;
        end else begin
            start_o <= launch;
            stop_o  <= cmd_stop;
        end
    end

    assign busy_o = (state_q == ST_BUSY);

    p_launch_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !cmd_stop && !busy_o) |=> (busy_o && start_o));

    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    p_end_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stop || eng_done) |=> !busy_o);

    p_no_relaunch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !start_o);

endmodule

// File: rtl/cc_ctl_fields.sv
module cc_ctl_fields
    import cc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              busy_i,
    input  logic              start_acc_i,
    output logic [1:0]        keysz_o,
    output logic [7:0]        opmode_o,
    output logic              encrypt_o,
    output logic              dma_en_o,
    output logic              cascade_o,
    output logic              swap_in_o,
    output logic              swap_out_o,
    output logic [1:0]        chan_o,
    output logic              last_o,
    output logic              prot_o,
    output logic              wipe_o,
    output logic [WORD_W-1:0] rdata_o
);

    logic [1:0] keysz_q;
    logic [7:0] opmode_q;
    logic       enc_q;
    logic       dma_q;
    logic       casc_q;
    logic       swin_q;
    logic       swout_q;
    logic [1:0] chan_q;
    logic [4:0] unlk_q;
    logic       prot_q;
    logic       last_q;
    logic       unused_bits;

    assign unused_bits = ^{wdata_i[4], wdata_i[21:17], wdata_i[B_START], wdata_i[B_STOP]};

    assign wipe_o = wr_i && !busy_i && !wdata_i[B_PROT]
                    && (wdata_i[30:26] == UNLOCK_CODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            keysz_q  <= '0;
            opmode_q <= '0;
            enc_q    <= 1'b0;
            dma_q    <= 1'b0;
            casc_q   <= 1'b0;
            swin_q   <= 1'b0;
            swout_q  <= 1'b0;
            chan_q   <= '0;
            unlk_q   <= '0;
            prot_q   <= 1'b0;
        end else if (wr_i) begin
            opmode_q <= wdata_i[15:8];
            enc_q    <= wdata_i[B_ENC];
            dma_q    <= wdata_i[B_DMA];
            casc_q   <= wdata_i[B_CASCADE];
            swin_q   <= wdata_i[B_SWIN];
            swout_q  <= wdata_i[B_SWOUT];
            chan_q   <= wdata_i[25:24];
            if (!busy_i) begin
                keysz_q <= wdata_i[3:2];
                unlk_q  <= wdata_i[30:26];
            end
            if (wdata_i[B_PROT]) begin
                prot_q <= 1'b1;
            end else if (wipe_o) begin
                prot_q <= 1'b0;
            end
        end
    end

    // last-block flag: must be rewritten for every start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else if (start_acc_i) begin
            last_q <= wr_i && wdata_i[B_LAST];
        end else if (wr_i && wdata_i[B_LAST]) begin
            last_q <= 1'b1;
        end
    end

    assign keysz_o    = keysz_q;
    assign opmode_o   = opmode_q;
    assign encrypt_o  = enc_q;
    assign dma_en_o   = dma_q;
    assign cascade_o  = casc_q;
    assign swap_in_o  = swin_q;
    assign swap_out_o = swout_q;
    assign chan_o     = chan_q;
    assign last_o     = last_q;
    assign prot_o     = prot_q;

    always_comb begin
        rdata_o              = '0;
        rdata_o[3:2]         = keysz_q;
        rdata_o[B_CASCADE]   = casc_q;
        rdata_o[B_DMA]       = dma_q;
        rdata_o[15:8]        = opmode_q;
        rdata_o[B_ENC]       = enc_q;
        rdata_o[B_SWOUT]     = swout_q;
        rdata_o[B_SWIN]      = swin_q;
        rdata_o[25:24]       = chan_q;
        rdata_o[30:26]       = unlk_q;
        rdata_o[B_PROT]      = prot_q;
    end

    p_keysz_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(keysz_q));

    p_unlock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(unlk_q));

    p_prot_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_q && !wipe_o) |=> prot_q);

    p_prot_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i[B_PROT]) |=> prot_q);

    p_last_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_acc_i && !wdata_i[B_LAST]) |=> !last_q);

endmodule

// File: rtl/cc_key_bank.sv
module cc_key_bank
    import cc_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int KEY_WORDS = 8,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int KW_W     = $clog2(KEY_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_i,
    input  logic [CH_W-1:0]             acc_ch_i,
    input  logic [KW_W-1:0]             acc_word_i,
    input  logic [WORD_W-1:0]           wdata_i,
    input  logic                        wipe_i,
    input  logic                        prot_i,
    input  logic [CH_W-1:0]             sel_ch_i,
    input  logic [1:0]                  keysz_i,
    output logic [WORD_W-1:0]           rdata_o,
    output logic [KEY_WORDS*WORD_W-1:0] key_o
);

    localparam int W_SHORT = KEY_WORDS / 2;
    localparam int W_MID   = (KEY_WORDS * 3) / 4;

    logic [WORD_W-1:0] mem_q [NUM_CH][KEY_WORDS];
    logic [KW_W:0]     live_words;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                for (int w = 0; w < KEY_WORDS; w++) begin
                    mem_q[c][w] <= '0;
                end
            end
        end else if (wipe_i) begin
            for (int c = 0; c < NUM_CH; c++) begin
                for (int w = 0; w < KEY_WORDS; w++) begin
                    mem_q[c][w] <= '0;
                end
            end
        end else if (wr_i) begin
            mem_q[acc_ch_i][acc_word_i] <= wdata_i;
        end
    end

    assign rdata_o = prot_i ? '0 : mem_q[acc_ch_i][acc_word_i];

    always_comb begin
        unique case (keysz_i)
            2'd0:    live_words = (KW_W+1)'(W_SHORT);
            2'd1:    live_words = (KW_W+1)'(W_MID);
            default: live_words = (KW_W+1)'(KEY_WORDS);
        endcase
    end

    for (genvar gw = 0; gw < KEY_WORDS; gw++) begin : g_keyword
        assign key_o[gw*WORD_W +: WORD_W] =
            ((KW_W+1)'(gw) < live_words) ? mem_q[sel_ch_i][gw] : '0;
    end

    p_wipe_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_i |=> (key_o == '0));

    p_top_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (keysz_i == 2'd0) |-> (key_o[KEY_WORDS*WORD_W-1 -: WORD_W] == '0));

endmodule

// File: rtl/cipher_ctl_regs.sv
module cipher_ctl_regs
    import cc_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int KEY_WORDS = 8,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int KW_W     = $clog2(KEY_WORDS),
    localparam int ADDR_W   = CH_W + KW_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [WORD_W-1:0]           bus_wdata,
    output logic [WORD_W-1:0]           bus_rdata,
    input  logic                        eng_done,
    output logic                        busy_o,
    output logic                        start_o,
    output logic                        stop_o,
    output logic                        last_o,
    output logic [1:0]                  keysz_o,
    output logic [7:0]                  opmode_o,
    output logic                        encrypt_o,
    output logic                        dma_en_o,
    output logic                        cascade_o,
    output logic                        swap_in_o,
    output logic                        swap_out_o,
    output logic [1:0]                  chan_o,
    output logic [KEY_WORDS*WORD_W-1:0] key_o
);

    localparam logic [ADDR_W-1:0] A_CTL  = '0;
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);

    logic              in_keys;
    logic              wr_ctl;
    logic              wr_key;
    logic              cmd_start;
    logic              cmd_stop;
    logic              start_acc;
    logic              prot;
    logic              wipe;
    logic [WORD_W-1:0] ctl_rdata;
    logic [WORD_W-1:0] key_rdata;
    logic [CH_W-1:0]   sel_ch;

    assign in_keys   = bus_addr[ADDR_W-1];
    assign wr_ctl    = bus_sel && bus_we && (bus_addr == A_CTL);
    assign wr_key    = bus_sel && bus_we && in_keys;
    assign cmd_start = wr_ctl && bus_wdata[B_START];
    assign cmd_stop  = wr_ctl && bus_wdata[B_STOP];
    assign start_acc = cmd_start && !cmd_stop && !busy_o;
    assign sel_ch    = CH_W'(chan_o);

    cc_busy_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .eng_done  (eng_done),
        .busy_o    (busy_o),
        .start_o   (start_o),
        .stop_o    (stop_o)
    );

    cc_ctl_fields u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (wr_ctl),
        .wdata_i     (bus_wdata),
        .busy_i      (busy_o),
        .start_acc_i (start_acc),
        .keysz_o     (keysz_o),
        .opmode_o    (opmode_o),
        .encrypt_o   (encrypt_o),
        .dma_en_o    (dma_en_o),
        .cascade_o   (cascade_o),
        .swap_in_o   (swap_in_o),
        .swap_out_o  (swap_out_o),
        .chan_o      (chan_o),
        .last_o      (last_o),
        .prot_o      (prot),
        .wipe_o      (wipe),
        .rdata_o     (ctl_rdata)
    );

    cc_key_bank #(
        .NUM_CH    (NUM_CH),
        .KEY_WORDS (KEY_WORDS)
    ) u_keys (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_key),
        .acc_ch_i   (bus_addr[KW_W +: CH_W]),
        .acc_word_i (bus_addr[KW_W-1:0]),
        .wdata_i    (bus_wdata),
        .wipe_i     (wipe),
        .prot_i     (prot),
        .sel_ch_i   (sel_ch),
        .keysz_i    (keysz_o),
        .rdata_o    (key_rdata),
        .key_o      (key_o)
    );

    always_comb begin
        if (in_keys) begin
            bus_rdata = key_rdata;
        end else if (bus_addr == A_CTL) begin
            bus_rdata = ctl_rdata;
        end else if (bus_addr == A_STAT) begin
            bus_rdata = {{(WORD_W-1){1'b0}}, busy_o};
        end else begin
            bus_rdata = '0;
        end
    end

    p_prot_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && in_keys && bus_rdata != '0) |-> !bus_rdata[0] || !ctl_rdata[B_PROT]);

    p_cmd_bits_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CTL) |-> (bus_rdata[B_START] == 1'b0 && bus_rdata[B_STOP] == 1'b0
                                 && bus_rdata[B_LAST] == 1'b0));

    p_status_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_STAT) |-> (bus_rdata[0] == busy_o));

endmodule

// File: tb/tb_cipher_ctl_regs.sv
module tb_cipher_ctl_regs;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_we = 1'b0;
    logic [5:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         eng_done = 1'b0;
    logic         busy_o, start_o, stop_o, last_o;
    logic [1:0]   keysz_o, chan_o;
    logic [7:0]   opmode_o;
    logic         encrypt_o, dma_en_o, cascade_o, swap_in_o, swap_out_o;
    logic [255:0] key_o;

    int n_vec = 0;
    int n_bad = 0;
    bit reported = 1'b0;

    always #10 clk = ~clk;

    cipher_ctl_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_done(eng_done), .busy_o(busy_o), .start_o(start_o), .stop_o(stop_o),
        .last_o(last_o), .keysz_o(keysz_o), .opmode_o(opmode_o),
        .encrypt_o(encrypt_o), .dma_en_o(dma_en_o), .cascade_o(cascade_o),
        .swap_in_o(swap_in_o), .swap_out_o(swap_out_o), .chan_o(chan_o),
        .key_o(key_o)
    );

    task automatic chk(input string req, input logic [255:0] got, input logic [255:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        end
        $finish;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
    endtask

    function automatic logic [31:0] kv(input int c, input int w);
        return 32'h1000_0000 * (c + 1) + 32'h0101_0101 * (w + 1) + 32'h0000_00A0;
    endfunction

    function automatic logic [255:0] kexp(input int c, input int sz);
        logic [255:0] r = '0;
        int live = (sz == 0) ? 4 : (sz == 1) ? 6 : 8;
        for (int w = 0; w < live; w++) r[w*32 +: 32] = kv(c, w);
        return r;
    endfunction

    task automatic load_keys();
        for (int c = 0; c < 4; c++)
            for (int w = 0; w < 8; w++)
                wr(6'(32 + 8*c + w), kv(c, w));
    endtask

    initial begin
        #(20 * 190000);
        n_vec++; n_bad++;
        $display("FAIL watchdog got=hung exp=finished");
        report();
    end

    initial begin
        logic [31:0] d;
        logic [4:0]  ops [8];
        ops[0] = 5'h00; ops[1] = 5'h01; ops[2] = 5'h02; ops[3] = 5'h03;
        ops[4] = 5'h04; ops[5] = 5'h10; ops[6] = 5'h11; ops[7] = 5'h12;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(6'd0, d);  chk("R1 ctl", 256'(d), 256'h0);
        rd(6'd1, d);  chk("R1 status", 256'(d), 256'h0);
        rd(6'd45, d); chk("R1 key", 256'(d), 256'h0);
        chk("R1 busy", 256'(busy_o), 256'h0);
        chk("R1 key_o", key_o, 256'h0);

        // R9 key map and length masking
        load_keys();
        for (int c = 0; c < 4; c++)
            for (int w = 0; w < 8; w++) begin
                rd(6'(32 + 8*c + w), d);
                chk("R9 key readback", 256'(d), 256'(kv(c, w)));
            end
        for (int c = 0; c < 4; c++)
            for (int s = 0; s < 4; s++) begin
                wr(6'd0, (32'(c) << 24) | (32'(s) << 2));
                chk("R9 key_o", key_o, kexp(c, s));
            end

        // R5 field sweep
        for (int o = 0; o < 8; o++)
            for (int v = 0; v < 16; v++) begin
                logic [31:0] wd;
                wd = (32'(v & 3) << 24) | (32'((v >> 2) & 1) << 23) | (32'((v >> 3) & 1) << 22)
                   | (32'((v ^ (v >> 1)) & 1) << 16) | (32'(ops[o]) << 8)
                   | (32'((v >> 2) & 1) << 7) | (32'((v >> 3) & 1) << 6) | (32'(v & 3) << 2)
                   | 32'h003E_0010;
                wr(6'd0, wd);
                rd(6'd0, d);
                chk("R5 readback", 256'(d), 256'(wd & 32'hFFC1_FFCC));
                chk("R5 outputs", 256'({opmode_o, encrypt_o, dma_en_o, cascade_o,
                                        swap_in_o, swap_out_o, chan_o, keysz_o}),
                    256'({wd[15:8], wd[16], wd[7], wd[6], wd[23], wd[22], wd[25:24], wd[3:2]}));
            end

        // R10 status write ignored
        wr(6'd1, 32'hFFFF_FFFF);
        rd(6'd1, d); chk("R10 status", 256'(d), 256'h0);

        // R2 start, R4 busy lock
        wr(6'd0, 32'h0000_0404);
        wr(6'd0, 32'h0000_0405);
        chk("R2 start pulse", 256'(start_o), 256'h1);
        chk("R2 busy", 256'(busy_o), 256'h1);
        rd(6'd0, d); chk("R2 start reads 0", 256'(d), 256'h0000_0404);
        chk("R2 pulse ends", 256'(start_o), 256'h0);
        rd(6'd1, d); chk("R10 busy bit", 256'(d), 256'h1);
        wr(6'd0, 32'h0001_1108);
        rd(6'd0, d); chk("R4 keysz locked", 256'(d), 256'h0001_1104);
        wr(6'd0, 32'h0001_1105);
        chk("R3 no pulse when busy", 256'(start_o), 256'h0);
        chk("R3 still busy", 256'(busy_o), 256'h1);
        done_pulse();
        chk("R3 done clears", 256'(busy_o), 256'h0);

        // R3 stop
        wr(6'd0, 32'h0000_0001);
        wr(6'd0, 32'h0000_0002);
        chk("R3 stop clears", 256'(busy_o), 256'h0);
        chk("R3 stop pulse", 256'(stop_o), 256'h1);
        wr(6'd0, 32'h0000_0003);
        chk("R3 stop wins busy", 256'(busy_o), 256'h0);
        chk("R3 stop wins pulse", 256'(start_o), 256'h0);

        // R6 last block
        wr(6'd0, 32'h0000_0020);
        chk("R6 last set", 256'(last_o), 256'h1);
        rd(6'd0, d); chk("R6 last reads 0", 256'(d), 256'h0);
        wr(6'd0, 32'h0000_0001);
        chk("R6 cleared by start", 256'(last_o), 256'h0);
        done_pulse();
        wr(6'd0, 32'h0000_0021);
        chk("R6 kept with start", 256'(last_o), 256'h1);
        done_pulse();

        // R7 protect
        wr(6'd0, 32'h8000_0000);
        rd(6'd0, d); chk("R7 flag", 256'(d), 256'h8000_0000);
        for (int k = 32; k < 64; k++) begin
            rd(6'(k), d); chk("R7 masked read", 256'(d), 256'h0);
        end
        chk("R7 key_o intact", key_o, kexp(0, 0));

        // R8 wrong patterns
        for (int p = 0; p < 32; p++) begin
            if (p != 22) begin
                wr(6'd0, 32'(p) << 26);
                rd(6'd0, d); chk("R8 bad pattern flag", 256'(d[31]), 256'h1);
                chk("R8 bad pattern key", key_o, kexp(0, 0));
            end
        end

        // R4 unlock while busy
        wr(6'd0, 32'h8000_0001);
        wr(6'd0, 32'h5800_0000);
        rd(6'd0, d); chk("R4 unlock ignored busy", 256'(d), 256'h8000_0000);
        done_pulse();
        chk("R4 key survives", key_o, kexp(0, 0));

        // R8 correct unlock
        wr(6'd0, 32'h5800_0008);
        rd(6'd0, d); chk("R8 flag cleared", 256'(d), 256'h5800_0008);
        chk("R8 key_o wiped", key_o, 256'h0);
        for (int k = 32; k < 64; k++) begin
            rd(6'(k), d); chk("R8 wiped word", 256'(d), 256'h0);
        end

        report();
    end

endmodule